// File: doc/BRIEF.md
# Single-Register Serial Port

This block is a serial transmitter and receiver that a CPU reaches through one 32-bit word. Reading the word returns the oldest unread received byte together with a transmitter-busy flag and a receive-data-ready flag. Writing the word can launch a byte on the serial output, discard the oldest received byte, or do both in the same write. The line format is fixed: 115200 bit/s, eight data bits, no parity, one stop bit. The bit period is derived from the `CLK_HZ` parameter.

Received bytes are placed in a 16-entry first-in first-out buffer. Software reads the byte at the head and then retires it with an explicit acknowledge write. The next byte becomes visible only after that write.

Top module: `mmio_uart`

## Requirements
- R1: The serial output idles high. Each transmitted frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts CLK_HZ/115200 clock cycles.
- R2: Read bits 7..0 hold the byte at the head of the receive buffer, and they read 0 while the buffer is empty.
- R3: Read bit 8 (transmitter busy) goes to 1 on the clock edge that accepts a transmit write. It stays 1 until the stop bit has been on the line for a full bit period.
- R4: Read bit 9 (data ready) is 1 when the receive buffer holds at least one byte and 0 when it is empty.
- R5: Read bits 31..10 are always 0.
- R6: A write with bit 10 set and the transmitter idle sends bits 7..0 as the next frame. The same write while the transmitter is busy is ignored and produces no later frame.
- R7: A write with bit 9 set removes the head byte of the receive buffer. When the buffer is empty, this write has no effect.
- R8: A single write with both bit 10 and bit 9 set starts a transmission and also removes the head byte.
- R9: The receive buffer holds 16 bytes in arrival order. A byte that completes while 16 bytes are held is dropped.
- R10: The receiver synchronises its input and samples each bit at mid-period. It discards a frame whose start bit is no longer low at mid-bit, and it discards a frame whose stop bit samples low.
- R11: Write bits 8 and 31..11 have no effect.
- R12: Pulling the asynchronous active-low reset low empties the receive buffer, idles the transmitter and drives the serial output high. The read word is then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the register, one cycle per write |
| wr_data | input | 32 | Write word: bit 10 transmit, bit 9 acknowledge, bits 7..0 byte |
| rd_data | output | 32 | Read word: bit 9 ready, bit 8 busy, bits 7..0 head byte |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
Some behaviours are checked by assertions on every cycle. The transmit line stays high whenever the busy flag is clear. Busy rises only after a transmit write, and the ready flag falls only after an acknowledge write. The head byte and the ready flag hold steady while no acknowledge is written. The buffer fill never exceeds its depth. Other behaviours can only be shown by the bench's scenarios: the bit-exact frame contents, arrival order through a full buffer, dropping of the seventeenth byte, rejection of glitches and of bad stop bits, and the effect of each write-bit combination.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int unsigned LINE_BAUD   = 115200;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned WB_SEND     = 10;
  localparam int unsigned WB_ACK      = 9;
  localparam int unsigned RB_READY    = 9;
  localparam int unsigned RB_BUSY     = 8;
  localparam int unsigned FRAME_BITS  = 10;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == LW'(DEPTH));
  assign level   = cnt_q;
  assign head    = mem[rd_ptr_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = bump(wr_ptr_q);
    if (do_pop)  rd_ptr_d = bump(rd_ptr_q);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_reg_pkg::*;
#(
  parameter int unsigned DIV = 16,
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] data,
  output logic              busy,
  output logic              txd
);
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [3:0]            bit_q, bit_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic                  busy_q, busy_d;
  logic                  tick;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, data, 1'b0};
        bit_d  = '0;
        cnt_d  = '0;
      end
    end else if (tick) begin
      cnt_d = '0;
      if (bit_q == 4'(FRAME_BITS - 1)) begin
        busy_d = 1'b0;
      end else begin
        bit_d = bit_q + 1'b1;
        sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      bit_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign txd  = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_reg_pkg::*;
#(
  parameter int unsigned DIV = 16,
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int unsigned HALF = (DIV / 2 > 0) ? DIV / 2 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  logic [2:0]        sync_q;
  logic              line, fall;
  rx_state_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              vld_q, vld_d;
  logic              full_tick, half_tick;

  assign line      = sync_q[1];
  assign fall      = sync_q[2] && !sync_q[1];
  assign full_tick = (cnt_q == CW'(DIV - 1));
  assign half_tick = (cnt_q == CW'(HALF - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    bit_d = bit_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    case (st_q)
      RX_IDLE: begin
        cnt_d = '0;
        if (fall) st_d = RX_START;
      end
      RX_START: begin
        if (half_tick) begin
          cnt_d = '0;
          bit_d = '0;
          st_d  = line ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (full_tick) begin
          cnt_d = '0;
          sh_d  = {line, sh_q[BYTE_W-1:1]};
          bit_d = bit_q + 1'b1;
          if (bit_q == 3'd7) st_d = RX_STOP;
        end
      end
      RX_STOP: begin
        if (full_tick) begin
          cnt_d = '0;
          vld_d = line;
          st_d  = RX_IDLE;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], rxd};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      vld_q  <= vld_d;
    end
  end

  assign byte_valid = vld_q;
  assign byte_data  = sh_q;
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import uart_reg_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned DIV       = CLK_HZ / LINE_BAUD,
  localparam int unsigned LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        rxd,
  output logic        txd
);
  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic              tx_busy, tx_start, ack;
  logic              rx_vld;
  logic [BYTE_W-1:0] rx_byte, head;
  logic              fifo_empty, fifo_full;
  logic [LW-1:0]     fifo_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign tx_start = wr_en && wr_data[WB_SEND] && !tx_busy;
  assign ack      = wr_en && wr_data[WB_ACK];

  uart_tx #(.DIV(DIV)) u_tx (
    .clk   (clk),
    .rst_n (rst_core_n),
    .start (tx_start),
    .data  (wr_data[BYTE_W-1:0]),
    .busy  (tx_busy),
    .txd   (txd)
  );

  uart_rx #(.DIV(DIV)) u_rx (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rxd        (rxd),
    .byte_valid (rx_vld),
    .byte_data  (rx_byte)
  );

  uart_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push      (rx_vld),
    .push_data (rx_byte),
    .pop       (ack),
    .head      (head),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .level     (fifo_level)
  );

  always_comb begin
    rd_data               = '0;
    rd_data[BYTE_W-1:0]   = fifo_empty ? '0 : head;
    rd_data[RB_BUSY]      = tx_busy;
    rd_data[RB_READY]     = !fifo_empty;
  end
endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [31:0]   wr_data,
  input logic [31:0]   rd_data,
  input logic          txd,
  input logic [LW-1:0] level
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[8] |-> txd);

  a_r3_busy_after_send: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[8]) |-> $past(wr_en && wr_data[10]));

  a_r6_busy_holds_on_send: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[8] && wr_en && wr_data[10]) |=> rd_data[8]);

  a_r7_ready_drops_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[9]) |-> $past(wr_en && wr_data[9]));

  a_r2_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[9] && !(wr_en && wr_data[9])) |=> (rd_data[9] && $stable(rd_data[7:0])));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
endmodule

bind mmio_uart mmio_uart_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .txd     (txd),
  .level   (fifo_level)
);

// File: tb/mmio_uart_tb_top.sv
`timescale 1ns/1ps
module mmio_uart_tb_top;
  localparam int unsigned CLK_HZ = 115200 * 16;
  localparam int unsigned DIV    = 16;
  localparam int unsigned NVEC   = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h55_AA, 16'h12_C9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rxd = 1'b1;
  logic        txd;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  mmio_uart #(.CLK_HZ(CLK_HZ), .FIFO_DEPTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rxd(rxd), .txd(txd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    @(negedge clk) rxd = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (DIV) @(negedge clk);
    end
    rxd = stop;
    repeat (DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic reg_write(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic capture_tx(output logic [7:0] b, output logic ok);
    int t;
    ok = 1'b0;
    b = '0;
    t = 0;
    while (txd !== 1'b0 && t < 40 * DIV) begin
      @(negedge clk);
      t++;
    end
    if (txd !== 1'b0) return;
    repeat (DIV / 2) @(negedge clk);
    if (txd !== 1'b0) return;
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = txd;
    end
    repeat (DIV) @(negedge clk);
    ok = (txd === 1'b1);
  endtask

  task automatic line_quiet(input string tag, input int cycles);
    int lows;
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    check(tag, 32'(lows), 32'd0);
  endtask

  function automatic logic [31:0] rword(input logic rdy, input logic bsy, input logic [7:0] d);
    return {22'd0, rdy, bsy, d};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic       ok;
    repeat (3) @(negedge clk);
    check("R12 reset read word", rd_data, 32'd0);
    check("R12 reset txd high", {31'd0, txd}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R4 R5 R6 R7: table walk
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v][7:0], 1'b1);
      check("R2 R4 R1 receive byte", rd_data, rword(1'b1, 1'b0, VEC[v][7:0]));
      check("R5 upper read bits", {10'd0, rd_data[31:10]}, 32'd0);
      reg_write(32'h0000_0200);
      check("R7 R4 ack empties", rd_data, 32'd0);
      reg_write(32'h0000_0400 | 32'(VEC[v][15:8]));
      check("R3 busy after send", {31'd0, rd_data[8]}, 32'd1);
      capture_tx(got, ok);
      check("R1 R6 frame ok", {31'd0, ok}, 32'd1);
      check("R1 R6 frame byte", {24'd0, got}, {24'd0, VEC[v][15:8]});
      repeat (DIV) @(negedge clk);
      check("R3 busy clear after frame", {31'd0, rd_data[8]}, 32'd0);
    end

    // R9: fill past depth, drain in order
    for (int i = 0; i < 17; i++) send_frame(8'(i * 7 + 3), 1'b1);
    for (int i = 0; i < 16; i++) begin
      check("R9 order", rd_data, rword(1'b1, 1'b0, 8'(i * 7 + 3)));
      reg_write(32'h0000_0200);
    end
    check("R9 seventeenth dropped", rd_data, 32'd0);

    // R7: ack on empty, then one byte
    reg_write(32'h0000_0200);
    check("R7 ack empty no effect", rd_data, 32'd0);
    send_frame(8'h5A, 1'b1);
    check("R7 byte after empty ack", rd_data, rword(1'b1, 1'b0, 8'h5A));
    reg_write(32'h0000_0200);

    // R6: send while busy is ignored
    reg_write(32'h0000_04C3);
    reg_write(32'h0000_0418);
    capture_tx(got, ok);
    check("R6 first byte kept", {23'd0, ok, got}, {23'd0, 1'b1, 8'hC3});
    repeat (DIV) @(negedge clk);
    line_quiet("R6 no second frame", 14 * DIV);

    // R8: send and ack in one write
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    reg_write(32'h0000_0677);
    check("R8 popped and busy", rd_data, rword(1'b1, 1'b1, 8'h22));
    capture_tx(got, ok);
    check("R8 sent byte", {23'd0, ok, got}, {23'd0, 1'b1, 8'h77});
    repeat (DIV) @(negedge clk);
    reg_write(32'h0000_0200);

    // R11: ignored write bits
    send_frame(8'h33, 1'b1);
    reg_write(32'hFFFF_F9FF);
    check("R11 no pop no send", rd_data, rword(1'b1, 1'b0, 8'h33));
    line_quiet("R11 line idle", 12 * DIV);
    reg_write(32'h0000_0200);

    // R10: glitch and bad stop bit
    @(negedge clk) rxd = 1'b0;
    repeat (DIV / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * DIV) @(negedge clk);
    check("R10 glitch rejected", rd_data, 32'd0);
    send_frame(8'h44, 1'b0);
    repeat (DIV) @(negedge clk);
    check("R10 bad stop rejected", rd_data, 32'd0);
    send_frame(8'h96, 1'b1);
    check("R10 good frame after", rd_data, rword(1'b1, 1'b0, 8'h96));

    // R12: reset mid-run clears buffer
    send_frame(8'h01, 1'b1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset clears", rd_data, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 after release", rd_data, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule